// File: doc/BRIEF.md
# Strobe-Framed PCM Serial Port

This block is the serial side of a telephony voice codec. Once per 8 kHz frame it moves one 8-bit transmit byte out and one 8-bit receive byte in over a four-wire serial bus: a bit clock, an active-high framing strobe, serial data in and serial data out. The strobe is high for the timeslot, and both directions use that same timeslot. Each direction has a mute input. A raised mute replaces that direction's byte with a fixed quiet code.

A 3-bit select input sets the bit clock rate. The block decodes it into a rate in kHz and a flag that says whether a 4.096 MHz master clock must be supplied. The low rates need the master clock. The higher rates use the bit clock directly.

The port runs on a fast system clock. It synchronises the bus signals and acts on the detected edges of the bit clock. The core side uses a parallel byte interface: a transmit byte that is taken at the start of the slot, and a received byte that is shown with a one-cycle valid pulse.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, `dout_oe`, `rx_valid` and `tx_taken` are low.
- R2: The select code maps to a rate in kHz and a master-clock flag as follows: 3'b100 gives 128 with the flag set; 3'b101 gives 256 with the flag set; 3'b000 gives 512, 3'b001 gives 1536, 3'b010 gives 2048 and 3'b011 gives 4096, all with the flag clear.
- R3: The transmit byte is driven on `dout` most significant bit first. Each bit is updated after a rising bit-clock edge at which the strobe is high, with the first bit at the edge where the strobe is first seen high. `dout_oe` is high for those 8 bit periods.
- R4: `dout_oe` is low whenever the strobe is sampled low at a rising bit-clock edge.
- R5: `din` is sampled on falling bit-clock edges inside the slot, first bit into the MSB. After a high period of exactly 8 rising edges, the byte appears on `rx_byte` with one single-cycle `rx_valid` pulse. The pulse comes after the first rising edge at which the strobe is low again.
- R6: If `tx_mute` is high when the slot starts, the transmitted byte is the quiet code 8'h7F.
- R7: If `rx_mute` is high when the received byte is presented, `rx_byte` is 8'h7F.
- R8: A strobe high period of fewer than 8 bits gives no `rx_valid` pulse.
- R9: A strobe high period of more than 8 bits gives no `rx_valid` pulse. `dout_oe` drops at the 9th high sample.
- R10: Select codes 3'b110 and 3'b111 raise `cfg_err` and hold `dout_oe` low.
- R11: `tx_byte` is captured once, at the strobe's first high sample, and `tx_taken` pulses once. Changing `tx_byte` later in the slot does not affect `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast compared with the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Bit clock rate select code |
| bclk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot strobe |
| din | input | 1 | Serial receive data |
| tx_mute | input | 1 | Replace transmit byte with quiet code |
| rx_mute | input | 1 | Replace receive byte with quiet code |
| tx_byte | input | 8 | Parallel byte to transmit |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for the `dout` pad (low means high impedance) |
| tx_taken | output | 1 | One-cycle pulse when `tx_byte` is captured |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse qualifying `rx_byte` |
| rate_khz | output | 13 | Decoded bit clock rate in kHz (0 if the code is invalid) |
| mclk_req | output | 1 | The selected rate needs the 4.096 MHz master clock |
| cfg_err | output | 1 | The select code is invalid |

## Verification
The assertions check these properties on every cycle:
- `rx_valid` is a single-cycle pulse, and it only follows a high period of exactly eight samples.
- The output enable is off in the cycle after an invalid code or a ninth strobe sample.
- `tx_taken` only follows a rising strobe edge.
- The master-clock flag only goes with the two low rates.

Some behaviours can only be shown by the bench's scenarios. These are:
- the MSB-first bit order on `dout`;
- the receive byte's contents;
- the quiet code substitution in each direction;
- the full rate table;
- a `tx_byte` change in mid-slot having no effect on the output.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
    localparam int SLOT_BITS = 8;
    localparam int CNT_W     = $clog2(SLOT_BITS + 1);
    localparam int RATE_W    = 13;

    typedef struct packed {
        logic [SLOT_BITS-1:0] tx_sh;
        logic [SLOT_BITS-1:0] rx_sh;
        logic [SLOT_BITS-1:0] rx_byte;
        logic [CNT_W-1:0]     hi_cnt;
        logic [CNT_W-1:0]     rx_cnt;
        logic                 active;
        logic                 oe;
        logic                 dout;
        logic                 rx_valid;
        logic                 tx_taken;
        logic                 bclk_prev;
        logic                 stb_prev;
    } slot_state_t;

    typedef struct packed {
        logic [RATE_W-1:0] khz;
        logic              mclk;
        logic              bad;
    } rate_info_t;
endpackage

// File: rtl/pcm_rate_decode.sv
module pcm_rate_decode
    import pcm_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    output logic [RATE_W-1:0] khz,
    output logic              mclk,
    output logic              bad
);
    rate_info_t info_d, info_q;

    always_comb begin
        info_d = '0;
        case (sel)
            3'b100:  begin info_d.khz = 13'd128;  info_d.mclk = 1'b1; end
            3'b101:  begin info_d.khz = 13'd256;  info_d.mclk = 1'b1; end
            3'b000:  info_d.khz = 13'd512;
            3'b001:  info_d.khz = 13'd1536;
            3'b010:  info_d.khz = 13'd2048;
            3'b011:  info_d.khz = 13'd4096;
            default: info_d.bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) info_q <= '0;
        else        info_q <= info_d;
    end

    assign khz  = info_q.khz;
    assign mclk = info_q.mclk;
    assign bad  = info_q.bad;

    // R2
    mclk_low_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk |-> (khz < 13'd512 && !bad));
endmodule

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_a,
    output logic [WIDTH-1:0] out_s
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[i] <= '0;
                else if (i == 0) stage_q[i] <= in_a;
                else             stage_q[i] <= stage_q[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    assign out_s = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_slot_engine.sv
module pcm_slot_engine
    import pcm_slot_pkg::*;
#(
    parameter logic [SLOT_BITS-1:0] QUIET = 8'h7F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_s,
    input  logic                 stb_s,
    input  logic                 din_s,
    input  logic                 tx_mute,
    input  logic                 rx_mute,
    input  logic                 cfg_bad,
    input  logic [SLOT_BITS-1:0] tx_byte,
    output logic                 dout,
    output logic                 dout_oe,
    output logic                 tx_taken,
    output logic [SLOT_BITS-1:0] rx_byte,
    output logic                 rx_valid
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOT_BITS);

    slot_state_t s_d, s_q;
    logic rise, fall;

    assign rise = bclk_s & ~s_q.bclk_prev;
    assign fall = ~bclk_s & s_q.bclk_prev;

    always_comb begin
        s_d           = s_q;
        s_d.rx_valid  = 1'b0;
        s_d.tx_taken  = 1'b0;
        s_d.bclk_prev = bclk_s;
        if (rise) begin
            s_d.stb_prev = stb_s;
            if (stb_s && !s_q.stb_prev) begin
                s_d.tx_sh    = tx_mute ? QUIET : tx_byte;
                s_d.dout     = s_d.tx_sh[SLOT_BITS-1];
                s_d.hi_cnt   = CNT_W'(1);
                s_d.rx_cnt   = '0;
                s_d.active   = 1'b1;
                s_d.tx_taken = 1'b1;
            end else if (stb_s && s_q.active) begin
                if (s_q.hi_cnt == FULL) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.hi_cnt = s_q.hi_cnt + CNT_W'(1);
                    s_d.tx_sh  = s_q.tx_sh << 1;
                    s_d.dout   = s_q.tx_sh[SLOT_BITS-2];
                end
            end else if (!stb_s) begin
                if (s_q.active && s_q.hi_cnt == FULL && s_q.rx_cnt == FULL) begin
                    s_d.rx_valid = 1'b1;
                    s_d.rx_byte  = rx_mute ? QUIET : s_q.rx_sh;
                end
                s_d.active = 1'b0;
            end
        end
        if (fall && s_q.active && s_q.rx_cnt < FULL) begin
            s_d.rx_sh  = {s_q.rx_sh[SLOT_BITS-2:0], din_s};
            s_d.rx_cnt = s_q.rx_cnt + CNT_W'(1);
        end
        s_d.oe = s_d.active & ~cfg_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout     = s_q.dout;
    assign dout_oe  = s_q.oe;
    assign tx_taken = s_q.tx_taken;
    assign rx_byte  = s_q.rx_byte;
    assign rx_valid = s_q.rx_valid;

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8
    rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> ($past(s_q.hi_cnt) == FULL && $past(s_q.rx_cnt) == FULL));
    // R9
    long_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && stb_s && s_q.active && s_q.hi_cnt == FULL) |=> !dout_oe);
    // R10
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> !dout_oe);
    // R11
    take_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |-> ($past(rise) && $past(stb_s) && !$past(s_q.stb_prev)));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter logic [SLOT_BITS-1:0] QUIET_CODE  = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        rate_sel,
    input  logic              bclk,
    input  logic              strobe,
    input  logic              din,
    input  logic              tx_mute,
    input  logic              rx_mute,
    input  logic [7:0]        tx_byte,
    output logic              dout,
    output logic              dout_oe,
    output logic              tx_taken,
    output logic [7:0]        rx_byte,
    output logic              rx_valid,
    output logic [12:0]       rate_khz,
    output logic              mclk_req,
    output logic              cfg_err
);
    logic [2:0] bus_s;

    pcm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_a  ({bclk, strobe, din}),
        .out_s (bus_s)
    );

    pcm_rate_decode u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (rate_sel),
        .khz   (rate_khz),
        .mclk  (mclk_req),
        .bad   (cfg_err)
    );

    pcm_slot_engine #(.QUIET(QUIET_CODE)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_s   (bus_s[2]),
        .stb_s    (bus_s[1]),
        .din_s    (bus_s[0]),
        .tx_mute  (tx_mute),
        .rx_mute  (rx_mute),
        .cfg_bad  (cfg_err),
        .tx_byte  (tx_byte),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .tx_taken (tx_taken),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );
endmodule

// File: tb/pcm_slot_port_bench.sv
module pcm_slot_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rate_sel = 3'b000;
    logic        bclk = 1'b0, strobe = 1'b0, din = 1'b0;
    logic        tx_mute = 1'b0, rx_mute = 1'b0;
    logic [7:0]  tx_byte = 8'h00;
    logic        dout, dout_oe, tx_taken, rx_valid, mclk_req, cfg_err;
    logic [7:0]  rx_byte;
    logic [12:0] rate_khz;

    int checks = 0, fails = 0;
    int vcnt = 0, tcnt = 0;
    logic [7:0] last_rx = 8'h00;
    logic [7:0] txbits;
    logic       oe_arr [16];
    bit         done = 1'b0;

    always #10 clk = ~clk;

    pcm_slot_port u_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bclk(bclk), .strobe(strobe),
        .din(din), .tx_mute(tx_mute), .rx_mute(rx_mute), .tx_byte(tx_byte),
        .dout(dout), .dout_oe(dout_oe), .tx_taken(tx_taken), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rate_khz(rate_khz), .mclk_req(mclk_req), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin vcnt++; last_rx = rx_byte; end
        if (tx_taken) tcnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bit period; returns dout and dout_oe sampled mid-high phase
    task automatic bit_period(input logic stb, input logic d, output logic o, output logic oe);
        @(negedge clk);
        strobe = stb; din = d; bclk = 1'b1;
        repeat (6) @(negedge clk);
        o = dout; oe = dout_oe;
        repeat (2) @(negedge clk);
        bclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic run_frame(input int len, input logic [7:0] tb, input logic [7:0] rb,
                             input bit chg);
        logic o, oe;
        tx_byte = tb;
        txbits = '0;
        bit_period(1'b0, 1'b0, o, oe);
        for (int i = 0; i < len; i++) begin
            bit_period(1'b1, (i < 8) ? rb[7-i] : 1'b0, o, oe);
            if (i < 8) txbits[7-i] = o;
            if (i < 16) oe_arr[i] = oe;
            if (chg && i == 0) tx_byte = ~tb;
        end
        bit_period(1'b0, 1'b0, o, oe);
        if (len > 0) oe_arr[len < 16 ? len : 15] = oe;
        bit_period(1'b0, 1'b0, o, oe);
    endtask

    task automatic t_reset;
        check(!dout_oe && !rx_valid && !tx_taken, "R1", {dout_oe, rx_valid, tx_taken}, 0);
    endtask

    task automatic t_rates;
        logic [2:0]  codes [6] = '{3'b100, 3'b101, 3'b000, 3'b001, 3'b010, 3'b011};
        int          khz   [6] = '{128, 256, 512, 1536, 2048, 4096};
        for (int i = 0; i < 6; i++) begin
            rate_sel = codes[i];
            repeat (3) @(negedge clk);
            check(rate_khz == 13'(khz[i]) && mclk_req == (i < 2) && !cfg_err, "R2",
                  rate_khz, khz[i]);
        end
        rate_sel = 3'b000;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_normal(input logic [7:0] tb, input logic [7:0] rb);
        int v0 = vcnt;
        int t0 = tcnt;
        run_frame(8, tb, rb, 1'b0);
        check(txbits == tb, "R3", txbits, tb);
        check(oe_arr[0] && oe_arr[7], "R3 oe", {oe_arr[0], oe_arr[7]}, 3);
        check(!oe_arr[8], "R4", oe_arr[8], 0);
        check(vcnt == v0 + 1 && last_rx == rb, "R5", last_rx, rb);
        check(tcnt == t0 + 1, "R11 taken", tcnt - t0, 1);
    endtask

    task automatic t_mutes;
        int v0;
        tx_mute = 1'b1;
        run_frame(8, 8'hA5, 8'h3C, 1'b0);
        check(txbits == 8'h7F, "R6", txbits, 8'h7F);
        tx_mute = 1'b0; rx_mute = 1'b1;
        v0 = vcnt;
        run_frame(8, 8'hA5, 8'h3C, 1'b0);
        check(txbits == 8'hA5, "R6 unmuted", txbits, 8'hA5);
        check(vcnt == v0 + 1 && last_rx == 8'h7F, "R7", last_rx, 8'h7F);
        rx_mute = 1'b0;
    endtask

    task automatic t_short;
        int v0 = vcnt;
        run_frame(5, 8'h12, 8'hF0, 1'b0);
        check(vcnt == v0, "R8", vcnt - v0, 0);
        check(!oe_arr[5], "R8 oe", oe_arr[5], 0);
    endtask

    task automatic t_long;
        int v0 = vcnt;
        run_frame(10, 8'h81, 8'h5A, 1'b0);
        check(vcnt == v0, "R9", vcnt - v0, 0);
        check(oe_arr[7] && !oe_arr[8], "R9 oe", {oe_arr[7], oe_arr[8]}, 2);
    endtask

    task automatic t_badcfg;
        rate_sel = 3'b110;
        repeat (3) @(negedge clk);
        check(cfg_err && rate_khz == 0, "R10 err", cfg_err, 1);
        run_frame(8, 8'hFF, 8'h00, 1'b0);
        check(!oe_arr[0] && !oe_arr[3] && !oe_arr[7], "R10 oe", oe_arr[3], 0);
        rate_sel = 3'b111;
        repeat (3) @(negedge clk);
        check(cfg_err, "R10 111", cfg_err, 1);
        rate_sel = 3'b000;
        repeat (3) @(negedge clk);
        check(!cfg_err, "R10 clear", cfg_err, 0);
    endtask

    task automatic t_latch;
        int t0 = tcnt;
        run_frame(8, 8'hC3, 8'h96, 1'b1);
        check(txbits == 8'hC3, "R11", txbits, 8'hC3);
        check(tcnt == t0 + 1, "R11 once", tcnt - t0, 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_rates();
        t_normal(8'hA5, 8'h3C);
        t_normal(8'h01, 8'h80);
        t_normal(8'hFF, 8'h00);
        t_mutes();
        t_short();
        t_long();
        t_badcfg();
        t_latch();
        t_normal(8'h5A, 8'hE7);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule